// File: doc/BRIEF.md
# Bit-Clock Pin Mode and De-emphasis Detector

A serial audio receiver sometimes has one input pin that does two jobs. The pin may carry an external serial bit clock, or it may be held at a static level that switches de-emphasis on or off. This block works in the master-clock domain and decides which of the two is happening. It counts rising edges on the pin within each phase of the frame clock. If the pin toggles fast enough, the block selects external bit-clock mode. If the pin then stops toggling for two whole frame periods, the block returns to internal mode.

In internal mode the pin level is sampled on every falling edge of the frame clock. A run of identical samples long enough to pass the debounce switches the de-emphasis enable. De-emphasis is held off in two cases: while the block is in external mode, and while the sample-rate logic reports high-rate operation.

There are two state machines. The mode machine has the states MODE_INT and MODE_EXT:
- MODE_INT goes to MODE_EXT on the edge-count hit.
- MODE_EXT goes to MODE_INT on the silence timeout.

The de-emphasis machine has the states DE_OFF and DE_ON:
- DE_OFF goes to DE_ON after a full run of low samples.
- DE_ON goes to DE_OFF after a full run of high samples.
- DE_ON goes to DE_OFF at once when the block enters external mode.

Top module: `bclk_pin_classifier`

## Requirements
- R1: After reset, ext_mode is 0 and deemph_en is 0.
- R2: In internal mode, the 16th pin rising edge inside one phase of the frame clock selects external mode (ext_mode=1). This holds for a high phase and for a low phase. Fifteen rising edges in one phase leave internal mode unchanged.
- R3: The pin rising-edge count restarts at every frame-clock edge, rising or falling. Fifteen pin rising edges in one phase followed by fifteen in the next do not select external mode.
- R4: In external mode, ext_mode returns to 0 on the third frame-clock falling edge after the last pin rising edge, provided no pin rising edge comes in between. The first of those three edges closes the partial frame, so this is two complete frame periods of silence. After the second such edge, ext_mode is still 1.
- R5: In internal mode, deemph_en becomes 1 when the pin is sampled low (0) on 5 consecutive frame-clock falling edges. Four such samples do not enable it.
- R6: deemph_en becomes 0 when the pin is sampled high (1) on 5 consecutive frame-clock falling edges. Four such samples leave it at 1.
- R7: A sample that differs from the previous sample restarts the run count at one. Three high samples, then one low, then four high samples leave deemph_en at 1.
- R8: While ext_mode is 1, deemph_en is 0 and the run count is held cleared. After a return to internal mode, deemph_en needs 5 new consecutive low samples before it becomes 1.
- R9: While high_rate is 1, deemph_en is 0 from the same cycle onward. The tracked de-emphasis state is kept, so deemph_en shows it again once high_rate returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Dual-purpose pin: bit clock or de-emphasis level (asynchronous) |
| frame_raw | input | 1 | Frame (left/right) clock (asynchronous) |
| high_rate | input | 1 | High-rate operation indicator, synchronous to clk |
| ext_mode | output | 1 | 1 while an external bit clock is detected |
| deemph_en | output | 1 | De-emphasis enable |

## Verification
A wrong edge count or a missed restart at a frame edge shows up on ext_mode. The flag rises one phase early or one phase late, or it rises when the edges are split across a frame edge. This is visible about three clocks after the frame edge that ends the phase concerned. A wrong silence counter shows up as ext_mode dropping one frame period too early or too late. A run counter that is not cleared on a mismatch, or not cleared in external mode, shows up as deemph_en changing one or more frame periods before the fifth matching sample. The bench checks deemph_en a few clocks after each such falling edge.

// File: rtl/bclk_pin_pkg.sv
package bclk_pin_pkg;

    typedef enum logic {
        MODE_INT = 1'b0,
        MODE_EXT = 1'b1
    } bclk_mode_e;

    typedef enum logic {
        DE_OFF = 1'b0,
        DE_ON  = 1'b1
    } deemph_e;

endpackage

// File: rtl/bclk_sync.sv
// Multi-stage synchronizer; also returns the previous synchronized level
// so that the consumer can derive edges.
module bclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_raw,
    input  logic rst_val,
    output logic lvl,
    output logic lvl_d
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{rst_val}};
            lvl_d <= rst_val;
        end else begin
            chain <= {chain[STAGES-2:0], d_raw};
            lvl_d <= chain[STAGES-1];
        end
    end

    assign lvl = chain[STAGES-1];
endmodule

// File: rtl/bclk_mode_fsm.sv
module bclk_mode_fsm
    import bclk_pin_pkg::*;
#(
    parameter int EDGE_LIMIT  = 16,
    parameter int LOSS_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_rise,
    input  logic fr_edge,
    input  logic fr_fall,
    output logic ext_mode
);
    localparam int CW = $clog2(EDGE_LIMIT + 1);
    localparam int QW = $clog2(LOSS_FRAMES + 2);

    bclk_mode_e state_q, state_d;
    logic [CW-1:0] edge_cnt;
    logic [QW-1:0] quiet_cnt;
    logic          hit, lost;

    // rising edges per frame phase, restarted at each frame edge, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            edge_cnt <= '0;
        else if (fr_edge)
            edge_cnt <= pin_rise ? CW'(1) : '0;
        else if (pin_rise && edge_cnt != CW'(EDGE_LIMIT))
            edge_cnt <= edge_cnt + CW'(1);
    end

    // frame falling edges since the last pin rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            quiet_cnt <= '0;
        else if (pin_rise || state_q == MODE_INT)
            quiet_cnt <= '0;
        else if (fr_fall && quiet_cnt != QW'(LOSS_FRAMES + 1))
            quiet_cnt <= quiet_cnt + QW'(1);
    end

    assign hit  = pin_rise && !fr_edge && (edge_cnt == CW'(EDGE_LIMIT - 1));
    assign lost = fr_fall && !pin_rise && (quiet_cnt == QW'(LOSS_FRAMES));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_INT: if (hit)  state_d = MODE_EXT;
            MODE_EXT: if (lost) state_d = MODE_INT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_INT;
        else        state_q <= state_d;
    end

    always_comb ext_mode = (state_q == MODE_EXT);
endmodule

// File: rtl/bclk_deemph_fsm.sv
module bclk_deemph_fsm
    import bclk_pin_pkg::*;
#(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fr_fall,
    input  logic pin_lvl,
    input  logic ext_mode,
    input  logic high_rate,
    output logic de_on,
    output logic deemph_en
);
    localparam int RW = $clog2(RUN_LEN + 1);

    deemph_e       state_q, state_d;
    logic [RW-1:0] run_q, run_next;
    logic          last_q;
    logic          full;

    always_comb begin
        if (pin_lvl != last_q)
            run_next = RW'(1);
        else if (run_q == RW'(RUN_LEN))
            run_next = run_q;
        else
            run_next = run_q + RW'(1);
    end

    assign full = fr_fall && (run_next == RW'(RUN_LEN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            last_q <= 1'b1;
        end else if (ext_mode) begin
            run_q  <= '0;
            last_q <= 1'b1;
        end else if (fr_fall) begin
            run_q  <= run_next;
            last_q <= pin_lvl;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DE_OFF: if (!ext_mode && full && !pin_lvl) state_d = DE_ON;
            DE_ON:  if (ext_mode || (full && pin_lvl)) state_d = DE_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DE_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        de_on     = (state_q == DE_ON);
        deemph_en = de_on && !ext_mode && !high_rate;
    end
endmodule

// File: rtl/bclk_pin_classifier.sv
module bclk_pin_classifier #(
    parameter int SYNC_STAGES = 2,
    parameter int EDGE_LIMIT  = 16,
    parameter int LOSS_FRAMES = 2,
    parameter int RUN_LEN     = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic frame_raw,
    input  logic high_rate,
    output logic ext_mode,
    output logic deemph_en
);
    logic pin_lvl, pin_lvl_d, fr_lvl, fr_lvl_d;
    logic pin_rise, fr_edge, fr_fall;
    logic de_on;

    bclk_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d_raw(pin_raw), .rst_val(1'b1),
        .lvl(pin_lvl), .lvl_d(pin_lvl_d)
    );

    bclk_sync #(.STAGES(SYNC_STAGES)) u_fr_sync (
        .clk(clk), .rst_n(rst_n), .d_raw(frame_raw), .rst_val(1'b0),
        .lvl(fr_lvl), .lvl_d(fr_lvl_d)
    );

    assign pin_rise = pin_lvl & ~pin_lvl_d;
    assign fr_edge  = fr_lvl ^ fr_lvl_d;
    assign fr_fall  = fr_lvl_d & ~fr_lvl;

    bclk_mode_fsm #(.EDGE_LIMIT(EDGE_LIMIT), .LOSS_FRAMES(LOSS_FRAMES)) u_mode (
        .clk(clk), .rst_n(rst_n), .pin_rise(pin_rise), .fr_edge(fr_edge),
        .fr_fall(fr_fall), .ext_mode(ext_mode)
    );

    bclk_deemph_fsm #(.RUN_LEN(RUN_LEN)) u_deemph (
        .clk(clk), .rst_n(rst_n), .fr_fall(fr_fall), .pin_lvl(pin_lvl),
        .ext_mode(ext_mode), .high_rate(high_rate), .de_on(de_on),
        .deemph_en(deemph_en)
    );
endmodule

// File: rtl/bclk_pin_classifier_chk.sv
module bclk_pin_classifier_chk (
    input logic clk,
    input logic rst_n,
    input logic high_rate,
    input logic ext_mode,
    input logic deemph_en,
    input logic pin_rise,
    input logic pin_lvl,
    input logic fr_edge,
    input logic fr_fall,
    input logic de_on
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!ext_mode && !deemph_en) || !rst_n);

    // R2
    ext_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_mode) |-> $past(pin_rise) && !$past(fr_edge));

    // R4
    ext_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_mode) |-> $past(fr_fall) && !$past(pin_rise));

    // R5
    de_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(de_on) |-> $past(fr_fall) && !$past(pin_lvl));

    // R8
    ext_blocks_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |-> !deemph_en);

    // R9
    high_rate_blocks_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        high_rate |-> !deemph_en);
endmodule

bind bclk_pin_classifier bclk_pin_classifier_chk u_chk (
    .clk(clk), .rst_n(rst_n), .high_rate(high_rate), .ext_mode(ext_mode),
    .deemph_en(deemph_en), .pin_rise(pin_rise), .pin_lvl(pin_lvl),
    .fr_edge(fr_edge), .fr_fall(fr_fall), .de_on(de_on)
);

// File: tb/bclk_pin_classifier_test.sv
module bclk_pin_classifier_test;
    localparam int PHASE = 96;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_raw = 1'b1;
    logic frame_raw = 1'b0;
    logic high_rate = 1'b0;
    logic ext_mode, deemph_en;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        bit    ext;
        bit    de;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    bclk_pin_classifier uut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .frame_raw(frame_raw),
        .high_rate(high_rate), .ext_mode(ext_mode), .deemph_en(deemph_en)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one frame phase: n pin pulses, then the pin rests at lvl, then frame toggles
    task automatic phase(input int n, input bit lvl);
        for (int i = 0; i < n; i++) begin
            pin_raw = 1'b1; step(2);
            pin_raw = 1'b0; step(2);
        end
        if (n == 0) pin_raw = lvl;
        step(PHASE - 4 * n);
        frame_raw = ~frame_raw;
    endtask

    // run quiet phases until the frame clock has just fallen
    task automatic quiet_fall(input bit lvl);
        do phase(0, lvl); while (frame_raw != 1'b0);
        step(6);
    endtask

    task automatic expect_out(input bit ext, input bit de, input string tag);
        exp_t e;
        e.ext = ext; e.de = de; e.tag = tag;
        sb_q.push_back(e);
        step(3);
    endtask

    // monitor: samples just after the edge, compares against the queue head
    initial begin
        forever begin
            exp_t e;
            wait (sb_q.size() != 0);
            @(posedge clk); #1;
            e = sb_q.pop_front();
            total++;
            if (ext_mode !== e.ext || deemph_en !== e.de) begin
                bad++;
                $display("FAIL %s: ext_mode=%0b exp=%0b deemph_en=%0b exp=%0b",
                         e.tag, ext_mode, e.ext, deemph_en, e.de);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: ext_mode=%0b exp=done deemph_en=%0b", ext_mode, deemph_en);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(5);
        rst_n = 1'b1;
        step(4);
        expect_out(0, 0, "R1 reset state");

        // R5: low runs
        for (int i = 0; i < 4; i++) quiet_fall(0);
        expect_out(0, 0, "R5 four low samples");
        quiet_fall(0);
        expect_out(0, 1, "R5 fifth low sample");

        // R9
        high_rate = 1'b1;
        expect_out(0, 0, "R9 high_rate forces off");
        high_rate = 1'b0;
        expect_out(0, 1, "R9 state kept after high_rate");

        // R7 / R6
        for (int i = 0; i < 3; i++) quiet_fall(1);
        quiet_fall(0);
        for (int i = 0; i < 4; i++) quiet_fall(1);
        expect_out(0, 1, "R7 broken run restarts count");
        quiet_fall(1);
        expect_out(0, 0, "R6 fifth high sample");

        for (int i = 0; i < 5; i++) quiet_fall(0);
        expect_out(0, 1, "R5 re-enabled");

        // R2 / R3
        phase(15, 0); step(6);
        expect_out(0, 1, "R2 fifteen edges stay internal");
        phase(15, 0); step(6);
        expect_out(0, 1, "R3 count restarts at frame edge");
        phase(16, 0); step(6);
        expect_out(1, 0, "R2 sixteen edges select external");
        expect_out(1, 0, "R8 de forced off in external");

        // make the last pulsed phase a low phase
        if (frame_raw == 1'b1) phase(16, 0);
        phase(16, 0); step(6);
        expect_out(1, 0, "R8 external held by edges");

        // R4 silence timeout
        quiet_fall(0);
        quiet_fall(0);
        expect_out(1, 0, "R4 still external after two falls");
        quiet_fall(0);
        expect_out(0, 0, "R4 internal after third fall");

        // R8 fresh run after external
        for (int i = 0; i < 4; i++) quiet_fall(0);
        expect_out(0, 0, "R8 run cleared during external");
        quiet_fall(0);
        expect_out(0, 1, "R8 five fresh low samples");

        wait (sb_q.size() == 0);
        step(3);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule